// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the run of column addresses that a memory burst visits. A request gives a starting column, a length code and an ordering bit. The block then issues one column address per accepted beat. The addresses stay inside an aligned block whose size is a power of two equal to the burst length. The low bits of the column step through that block, and the bits above it keep the value from the request.

Two orderings are available. In sequential order, the offset inside the block counts up from the start offset and wraps at the block boundary. In interleaved order, the offset is the start offset XOR the beat number. A stop input cuts a running burst short. This can be used for a burst terminate or for a truncation.

Requests come in through a valid/ready handshake. The request side is ready only while no burst is running. Beats go out through a second valid/ready handshake. When the consumer holds `out_ready` low, the block holds the current beat unchanged and does not advance. A beat counts as issued only on a cycle where `out_valid` and `out_ready` are both high.

Top module: `burst_col_sequencer`

## Requirements
- R1: After reset, `out_valid` is 0 and `req_ready` is 1.
- R2: A request with length code k of 1, 2 or 3 gives a burst of 2^k beats (2, 4 or 8). The first beat is presented in the cycle after the request is accepted. Once the last beat is accepted, `out_valid` is low in the next cycle.
- R3: With `req_order` = 0 (sequential), beat i has low bits equal to (start low bits + i) mod 2^k.
- R4: With `req_order` = 1 (interleaved), beat i has low bits equal to (start low bits) XOR i.
- R5: Column bits at position k and above equal the requested column for every beat of the burst.
- R6: `out_last` is high on beat 2^k - 1 and on no other beat.
- R7: While `out_valid` is high and `out_ready` is low, the next cycle shows the same `out_col` and `out_last`, and the beat does not advance.
- R8: `req_ready` is low whenever a burst is running. A request offered during a burst is ignored and does not change the running burst.
- R9: If `stop` is high at a clock edge while `out_valid` is high, `out_valid` is low in the next cycle, whether or not that beat was accepted.
- R10: A request with length code 0 or 4 to 7 is consumed but starts no burst: `out_valid` stays 0 and `req_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Burst request offered |
| req_ready | output | 1 | Request accepted on this cycle if offered (idle) |
| req_col | input | COL_W | Starting column address |
| req_len_code | input | CODE_W | Length code k, burst length 2^k |
| req_order | input | 1 | 0 sequential, 1 interleaved |
| stop | input | 1 | Ends the running burst after this edge |
| out_valid | output | 1 | A beat address is presented |
| out_ready | input | 1 | Consumer takes the presented beat |
| out_col | output | COL_W | Column address of the current beat |
| out_last | output | 1 | Current beat is the final one of the burst |

## Verification
The bench goes after start offsets that sit in the middle of a block, so that sequential order has to wrap. A design that lets the carry spill upward would change bits above the block, and the R5 and R3 checks would catch it. It checks interleaved order at offsets where XOR and addition give different results, so that swapping the two orderings shows up as a wrong address. Stalls from random back-pressure, including a stall on the last beat, would expose a design that advances or drops `out_last` without a handshake. Stops on the first beat and on the last beat, requests offered mid-burst, and the rejected length codes would expose a burst that overruns, a request that restarts the burst, or a phantom burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORDER_SEQ = 1'b0,
    ORDER_XOR = 1'b1
  } order_e;
endpackage

// File: rtl/burst_len_decode.sv
// Maps the length code to a legality flag and the mask of varying low bits.
module burst_len_decode #(
  parameter int MAX_LOG = 3,
  parameter int CODE_W  = 3
) (
  input  logic [CODE_W-1:0]  code,
  output logic               legal,
  output logic [MAX_LOG-1:0] mask
);
  always_comb begin
    legal = (code != '0) && (int'(code) <= MAX_LOG);
    mask  = '0;
    for (int b = 0; b < MAX_LOG; b++) begin
      mask[b] = legal && (b < int'(code));
    end
  end
endmodule

// File: rtl/beat_order.sv
// Forms the low column bits of one beat: ordered offset inside the mask,
// start bits kept outside it.
module beat_order
  import burst_seq_pkg::*;
#(
  parameter int MAX_LOG = 3
) (
  input  logic [MAX_LOG-1:0] first,
  input  logic [MAX_LOG-1:0] idx,
  input  logic [MAX_LOG-1:0] mask,
  input  order_e             kind,
  output logic [MAX_LOG-1:0] low
);
  logic [MAX_LOG-1:0] sum_bits;
  logic [MAX_LOG-1:0] xor_bits;
  logic [MAX_LOG-1:0] pick;

  assign sum_bits = first + idx;
  assign xor_bits = first ^ idx;
  assign pick     = (kind == ORDER_XOR) ? xor_bits : sum_bits;

  for (genvar g = 0; g < MAX_LOG; g++) begin : g_bit
    assign low[g] = mask[g] ? pick[g] : first[g];
  end
endmodule

// File: rtl/beat_counter.sv
// Tracks whether a burst runs and which beat is presented.
module beat_counter #(
  parameter int MAX_LOG = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               advance,
  input  logic               kill,
  input  logic [MAX_LOG-1:0] mask,
  output logic               busy,
  output logic [MAX_LOG-1:0] idx,
  output logic               last
);
  assign last = busy && (idx == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy && kill) begin
      busy <= 1'b0;
    end else if (busy && advance) begin
      if (last) begin
        busy <= 1'b0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_col_sequencer.sv
module burst_col_sequencer
  import burst_seq_pkg::*;
#(
  parameter int COL_W   = 10,
  parameter int MAX_LOG = 3,
  parameter int CODE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [COL_W-1:0]  req_col,
  input  logic [CODE_W-1:0] req_len_code,
  input  logic              req_order,
  input  logic              stop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [COL_W-1:0]  out_col,
  output logic              out_last
);
  localparam int UPPER_W = COL_W - MAX_LOG;

  logic               code_ok;
  logic [MAX_LOG-1:0] code_mask;
  logic               busy;
  logic [MAX_LOG-1:0] beat_idx;
  logic               beat_last;
  logic               load;
  logic [COL_W-1:0]   col_q;
  logic [MAX_LOG-1:0] mask_q;
  order_e             order_q;
  logic [MAX_LOG-1:0] low_bits;

  burst_len_decode #(.MAX_LOG(MAX_LOG), .CODE_W(CODE_W)) u_dec (
    .code  (req_len_code),
    .legal (code_ok),
    .mask  (code_mask)
  );

  assign req_ready = !busy;
  assign load      = req_valid && req_ready && code_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      mask_q  <= '0;
      order_q <= ORDER_SEQ;
    end else if (load) begin
      col_q   <= req_col;
      mask_q  <= code_mask;
      order_q <= order_e'(req_order);
    end
  end

  beat_counter #(.MAX_LOG(MAX_LOG)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .advance (out_ready),
    .kill    (stop),
    .mask    (mask_q),
    .busy    (busy),
    .idx     (beat_idx),
    .last    (beat_last)
  );

  beat_order #(.MAX_LOG(MAX_LOG)) u_ord (
    .first (col_q[MAX_LOG-1:0]),
    .idx   (beat_idx),
    .mask  (mask_q),
    .kind  (order_q),
    .low   (low_bits)
  );

  assign out_valid = busy;
  assign out_last  = beat_last;
  assign out_col   = {col_q[COL_W-1 -: UPPER_W], low_bits};
endmodule

// File: rtl/burst_col_sequencer_chk.sv
module burst_col_sequencer_chk #(
  parameter int COL_W   = 10,
  parameter int MAX_LOG = 3,
  parameter int CODE_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [CODE_W-1:0] req_len_code,
  input logic              stop,
  input logic              out_valid,
  input logic              out_ready,
  input logic [COL_W-1:0]  out_col,
  input logic              out_last
);
  logic bad_code;
  assign bad_code = (req_len_code == '0) || (int'(req_len_code) > MAX_LOG);

  assert_idle_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> req_ready);

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !stop) |=>
      (out_valid && $stable(out_col) && $stable(out_last)));

  assert_stop_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && stop) |=> !out_valid);

  assert_last_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);

  assert_upper_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last && !stop) |=>
      (out_col[COL_W-1:MAX_LOG] == $past(out_col[COL_W-1:MAX_LOG])));

  assert_bad_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && bad_code) |=> !out_valid);
endmodule

bind burst_col_sequencer burst_col_sequencer_chk #(
  .COL_W(COL_W), .MAX_LOG(MAX_LOG), .CODE_W(CODE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_len_code (req_len_code),
  .stop         (stop),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_col      (out_col),
  .out_last     (out_last)
);

// File: tb/test_burst_col_sequencer.sv
module test_burst_col_sequencer;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [COL_W-1:0] req_col = '0;
  logic [2:0]       req_len_code = '0;
  logic             req_order = 1'b0;
  logic             stop = 1'b0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [COL_W-1:0] out_col;
  logic             out_last;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  burst_col_sequencer i_burst_col_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_col(req_col), .req_len_code(req_len_code), .req_order(req_order),
    .stop(stop), .out_valid(out_valid), .out_ready(out_ready),
    .out_col(out_col), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_col(input int start, input int code, input bit ord, input int beat);
    int len = 1 << code;
    int lo  = start & 7;
    int nxt = ord ? (lo ^ beat) : (lo + beat);
    return (start & ~(len - 1)) | (nxt & (len - 1));
  endfunction

  task automatic run_burst(input int col, input int code, input bit ord,
                           input int stop_at, input int ready_pct);
    int  len;
    int  beat;
    bit  held;
    bit  done;
    @(negedge clk);
    req_valid = 1'b1; req_col = COL_W'(col); req_len_code = 3'(code);
    req_order = ord; stop = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    if (code < 1 || code > 3) begin
      chk(out_valid == 1'b0, "R10 no burst", int'(out_valid), 0);
      chk(req_ready == 1'b1, "R10 still ready", int'(req_ready), 1);
      return;
    end
    len = 1 << code; beat = 0; held = 1'b0; done = 1'b0;
    while (!done) begin
      chk(out_valid == 1'b1, "R2 beat present", int'(out_valid), 1);
      chk(int'(out_col) == exp_col(col, code, ord, beat),
          held ? "R7 held address" : (ord ? "R4 interleaved" : "R3 sequential"),
          int'(out_col), exp_col(col, code, ord, beat));
      chk((int'(out_col) >> code) == (col >> code), "R5 upper bits",
          int'(out_col) >> code, col >> code);
      chk(out_last == (beat == len - 1), "R6 last flag", int'(out_last), int'(beat == len - 1));
      chk(req_ready == 1'b0, "R8 busy not ready", int'(req_ready), 0);
      begin
        bit r  = int'($urandom % 100) < ready_pct;
        bit st = (beat == stop_at);
        out_ready = r;
        stop = st;
        if (($urandom % 4) == 0) begin
          req_valid = 1'b1;
          req_col = COL_W'($urandom);
          req_len_code = 3'd1;
          req_order = ~ord;
        end
        @(negedge clk);
        req_valid = 1'b0; out_ready = 1'b0; stop = 1'b0;
        if (st) begin
          chk(out_valid == 1'b0, "R9 stop ends burst", int'(out_valid), 0);
          done = 1'b1;
        end else if (r) begin
          beat++;
          held = 1'b0;
          if (beat == len) begin
            chk(out_valid == 1'b0, "R2 burst length", int'(out_valid), 0);
            chk(req_ready == 1'b1, "R8 ready after burst", int'(req_ready), 1);
            done = 1'b1;
          end
        end else begin
          held = 1'b1;
        end
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
    chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 idle valid", int'(out_valid), 0);
    // directed corners
    run_burst(10'h2F5, 3, 1'b0, -1, 100); // R3 wrap mid block
    run_burst(10'h2F5, 3, 1'b1, -1, 100); // R4
    run_burst(10'h0A3, 2, 1'b1, -1, 60);
    run_burst(10'h1FF, 1, 1'b0, -1, 50);
    run_burst(10'h3FE, 2, 1'b0, 0, 100);  // R9 stop on first beat
    run_burst(10'h006, 3, 1'b0, 7, 30);   // R9 stop on last beat
    run_burst(10'h155, 0, 1'b0, -1, 100); // R10
    run_burst(10'h155, 4, 1'b1, -1, 100); // R10
    run_burst(10'h155, 7, 1'b0, -1, 100); // R10
    for (int t = 0; t < 400; t++) begin
      int code = ($urandom % 8 == 0) ? int'($urandom % 8) : 1 + int'($urandom % 3);
      int sa   = ($urandom % 5 == 0) ? int'($urandom % 8) : -1;
      run_burst(int'($urandom % 1024), code, 1'($urandom), sa, 40 + int'($urandom % 61));
    end
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule